// File: doc/BRIEF.md
# Burst line fill sequencer

This block is the bus-master side of a cache line refill. A cacheable read that misses starts an access on a synchronous 32-bit bus. The sequencer asks the slave for burst mode and collects the line one long word per terminated clock. The fill begins at the long word the miss pointed to and wraps around the four-word line. Address, strobes and direction stay fixed for the whole access, so the outside world sees one bus cycle.

The burst request is only raised when the target cache is enabled, is not frozen, and the access is not part of a read-modify-write pair. When the slave does not acknowledge the request on the first terminated clock, the access becomes a single long-word transfer. A bus error, a cache-inhibit on a terminated clock, or an acknowledge dropped before the third beat ends the fill early. In that case the words already collected stay valid and a status code names the cause. Halt and bus-grant are only reported between accesses.

Top module: `line_fill_seq`

## Requirements
- R1: `brq_o` stays low for the whole access when `cache_en_i` was low or `cache_frz_i` was high in the cycle `start_i` was taken.
- R2: `brq_o` stays low for the whole access when `rmw_i` was high in the cycle `start_i` was taken.
- R3: Burst mode is entered only when `sterm_i` and `back_i` are both high while `brq_o` is high on the first terminated clock. Otherwise that clock ends the access as a single transfer: one valid bit, `status_o` = 0 (done).
- R4: While `as_o` is high, `ds_o` is also high and `addr_o` holds the address given with `start_i`, without change.
- R5: Each clock with `sterm_i` high (and no abort) stores `data_i` into word slot k of `line_o` (bits 32k+31..32k) and sets `vld_o[k]`. The first slot is address bits [3:2] of the miss, and the following slots count up modulo 4. Clocks without `sterm_i` store nothing.
- R6: `brq_o` is low once three beats have been stored. The fourth terminated clock is stored even with `back_i` low, and it ends the access with `status_o` = 0.
- R7: `berr_i` high during an access ends it on that clock. That clock stores nothing, and `status_o` becomes 2.
- R8: `inhibit_i` high together with `sterm_i` (no bus error) ends the access. That clock stores nothing, and `status_o` becomes 1.
- R9: `back_i` low on a terminated second or third beat of a burst stores that beat and ends the access with `status_o` = 3.
- R10: `halted_o` and `grant_o` are low while `as_o` is high. When idle, `halted_o` follows `halt_i` and `grant_o` follows `busreq_i` (when `halt_i` is low), each delayed by one register. `start_i` is ignored while either is high.
- R11: `done_o` is high for exactly one clock after the clock that ends an access. `vld_o`, `line_o` and `status_o` keep their values until the next access starts, and taking a start clears `vld_o`. After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Cacheable read miss, begin a fill |
| addr_i | input | 32 | Byte address of the miss |
| cache_en_i | input | 1 | Target cache enabled |
| cache_frz_i | input | 1 | Target cache frozen |
| rmw_i | input | 1 | Access belongs to a read-modify-write pair |
| sterm_i | input | 1 | Synchronous termination from slave |
| back_i | input | 1 | Slave accepts burst, can supply one more word |
| inhibit_i | input | 1 | Slave marks data not cacheable |
| berr_i | input | 1 | Bus error |
| data_i | input | 32 | Read data |
| halt_i | input | 1 | Halt request |
| busreq_i | input | 1 | Alternate master bus request |
| as_o | output | 1 | Address strobe, high for the whole access |
| ds_o | output | 1 | Data strobe, high for the whole access |
| addr_o | output | 32 | Held access address |
| brq_o | output | 1 | Burst request |
| line_o | output | 128 | Collected line, word k at bits 32k+31..32k |
| vld_o | output | 4 | Per-word valid flags |
| done_o | output | 1 | One-clock end-of-access pulse |
| status_o | output | 2 | 0 done, 1 inhibited, 2 bus error, 3 acknowledge lost |
| halted_o | output | 1 | Master halted at an access boundary |
| grant_o | output | 1 | Bus granted at an access boundary |

## Verification
All inputs are driven just after a falling edge, and outputs are compared at the next falling edge, half a period after the rising edge that registers them. `as_o` and `brq_o` rise one edge after `start_i` is taken. Each stored beat appears in `vld_o` and `line_o` one edge after its terminated clock, and on the ending clock `done_o`, `status_o` and the drop of `as_o` arrive together one edge later. `halted_o` and `grant_o` go through one register, so the bench reads them one edge after the access ends or after the request changes while idle.

// File: rtl/line_fill_pkg.sv
package line_fill_pkg;

    typedef enum logic [1:0] {
        FILL_OK      = 2'd0,
        FILL_INH     = 2'd1,
        FILL_BERR    = 2'd2,
        FILL_ACKLOSS = 2'd3
    } fill_stat_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUS  = 1'b1
    } phase_e;

endpackage

// File: rtl/fill_beat_track.sv
module fill_beat_track #(
    parameter int WORDS = 4,
    parameter int IW    = $clog2(WORDS),
    parameter int CW    = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IW-1:0]    base_i,
    input  logic             adv_i,
    output logic [IW-1:0]    ptr_o,
    output logic [CW-1:0]    cnt_o,
    output logic [WORDS-1:0] vld_o
);

    typedef struct packed {
        logic [IW-1:0]    ptr;
        logic [CW-1:0]    cnt;
        logic [WORDS-1:0] vld;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (load_i) begin
            trk_d.ptr = base_i;
            trk_d.cnt = '0;
            trk_d.vld = '0;
        end else if (adv_i) begin
            trk_d.vld[trk_q.ptr] = 1'b1;
            trk_d.cnt = trk_q.cnt + CW'(1);
            if (trk_q.ptr == IW'(WORDS - 1)) begin
                trk_d.ptr = '0;
            end else begin
                trk_d.ptr = trk_q.ptr + IW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign ptr_o = trk_q.ptr;
    assign cnt_o = trk_q.cnt;
    assign vld_o = trk_q.vld;

    AST_ONE_NEW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> ($countones(vld_o) == $past($countones(vld_o)) + 1)); // R5

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (vld_o == '0)); // R11

endmodule

// File: rtl/fill_line_store.sv
module fill_line_store #(
    parameter int WORDS = 4,
    parameter int DW    = 32,
    parameter int IW    = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [IW-1:0]       idx_i,
    input  logic [DW-1:0]       data_i,
    output logic [WORDS*DW-1:0] line_o
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DW-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (wr_i && (idx_i == IW'(g))) begin
                word_d = data_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign line_o[g*DW +: DW] = word_q;

        AST_WORD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_i && (idx_i == IW'(g))) |=> $stable(line_o[g*DW +: DW])); // R11
    end

endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq
    import line_fill_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WORDS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [AW-1:0]       addr_i,
    input  logic                cache_en_i,
    input  logic                cache_frz_i,
    input  logic                rmw_i,
    input  logic                sterm_i,
    input  logic                back_i,
    input  logic                inhibit_i,
    input  logic                berr_i,
    input  logic [DW-1:0]       data_i,
    input  logic                halt_i,
    input  logic                busreq_i,
    output logic                as_o,
    output logic                ds_o,
    output logic [AW-1:0]       addr_o,
    output logic                brq_o,
    output logic [WORDS*DW-1:0] line_o,
    output logic [WORDS-1:0]    vld_o,
    output logic                done_o,
    output logic [1:0]          status_o,
    output logic                halted_o,
    output logic                grant_o
);

    localparam int IW  = $clog2(WORDS);
    localparam int CW  = $clog2(WORDS + 1);
    localparam int LSH = $clog2(DW / 8);

    typedef struct packed {
        phase_e     ph;
        logic [AW-1:0] addr;
        logic       ok;
        logic       done;
        fill_stat_e stat;
        logic       halt_s;
        logic       br_s;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [IW-1:0] ptr;
    logic [CW-1:0] cnt;
    logic          busy, idle, hold, take, adv, fin, brq;

    always_comb begin
        idle  = (seq_q.ph == PH_IDLE);
        busy  = !idle;
        brq   = busy && seq_q.ok && (cnt < CW'(WORDS - 1));
        hold  = idle && (seq_q.halt_s || seq_q.br_s);
        take  = idle && start_i && !hold;
        adv   = 1'b0;
        fin   = 1'b0;

        seq_d        = seq_q;
        seq_d.done   = 1'b0;
        seq_d.halt_s = halt_i;
        seq_d.br_s   = busreq_i;

        if (take) begin
            seq_d.ph   = PH_BUS;
            seq_d.addr = addr_i;
            seq_d.ok   = cache_en_i && !cache_frz_i && !rmw_i;
            seq_d.stat = FILL_OK;
        end

        if (busy) begin
            if (berr_i) begin
                fin        = 1'b1;
                seq_d.stat = FILL_BERR;
            end else if (sterm_i && inhibit_i) begin
                fin        = 1'b1;
                seq_d.stat = FILL_INH;
            end else if (sterm_i) begin
                adv = 1'b1;
                if (cnt == CW'(WORDS - 1)) begin
                    fin        = 1'b1;
                    seq_d.stat = FILL_OK;
                end else if (cnt == '0) begin
                    if (!(brq && back_i)) begin
                        fin        = 1'b1;
                        seq_d.stat = FILL_OK;
                    end
                end else if (!back_i) begin
                    fin        = 1'b1;
                    seq_d.stat = FILL_ACKLOSS;
                end
            end
            if (fin) begin
                seq_d.ph   = PH_IDLE;
                seq_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, stat: FILL_OK, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    fill_beat_track #(.WORDS(WORDS)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (take),
        .base_i (addr_i[LSH +: IW]),
        .adv_i  (adv),
        .ptr_o  (ptr),
        .cnt_o  (cnt),
        .vld_o  (vld_o)
    );

    fill_line_store #(.WORDS(WORDS), .DW(DW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (adv),
        .idx_i  (ptr),
        .data_i (data_i),
        .line_o (line_o)
    );

    assign as_o     = busy;
    assign ds_o     = busy;
    assign addr_o   = seq_q.addr;
    assign brq_o    = brq;
    assign done_o   = seq_q.done;
    assign status_o = seq_q.stat;
    assign halted_o = idle && seq_q.halt_s;
    assign grant_o  = idle && seq_q.br_s && !seq_q.halt_s;

    AST_NO_BRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(as_o) && $past(!cache_en_i || cache_frz_i)) |-> !brq_o); // R1

    AST_NO_BRQ_RMW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(as_o) && $past(rmw_i)) |-> !brq_o); // R2

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (as_o && $past(as_o)) |-> ($stable(addr_o) && ds_o)); // R4

    AST_LAST_NO_BRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (as_o && ($countones(vld_o) == WORDS - 1)) |-> !brq_o); // R6

    AST_BERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (as_o && berr_i) |=> (!as_o && status_o == FILL_BERR)); // R7

    AST_INH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (as_o && sterm_i && inhibit_i && !berr_i) |=> (!as_o && status_o == FILL_INH)); // R8

    AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        as_o |-> (!halted_o && !grant_o)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11

endmodule

// File: tb/line_fill_seq_tb_top.sv
module line_fill_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0000_4000;

    logic clk = 1'b0;
    logic rst_n;
    logic start_i, cache_en_i, cache_frz_i, rmw_i;
    logic sterm_i, back_i, inhibit_i, berr_i, halt_i, busreq_i;
    logic [31:0] addr_i, data_i;
    logic as_o, ds_o, brq_o, done_o, halted_o, grant_o;
    logic [31:0] addr_o;
    logic [127:0] line_o;
    logic [3:0] vld_o;
    logic [1:0] status_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [31:0] m_line [4];
    logic [3:0]  m_vld;
    int          m_ptr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    line_fill_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .cache_en_i(cache_en_i), .cache_frz_i(cache_frz_i), .rmw_i(rmw_i),
        .sterm_i(sterm_i), .back_i(back_i), .inhibit_i(inhibit_i), .berr_i(berr_i),
        .data_i(data_i), .halt_i(halt_i), .busreq_i(busreq_i),
        .as_o(as_o), .ds_o(ds_o), .addr_o(addr_o), .brq_o(brq_o), .line_o(line_o),
        .vld_o(vld_o), .done_o(done_o), .status_o(status_o),
        .halted_o(halted_o), .grant_o(grant_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic open_acc(input int w, input logic en, input logic frz, input logic rmw);
        addr_i      = BASE | (w << 2);
        cache_en_i  = en;
        cache_frz_i = frz;
        rmw_i       = rmw;
        start_i     = 1'b1;
        tick();
        start_i     = 1'b0;
        m_vld       = '0;
        m_ptr       = w;
    endtask

    task automatic put(input logic st, input logic bk, input logic inh, input logic be,
                       input logic [31:0] d, input logic lat);
        sterm_i = st; back_i = bk; inhibit_i = inh; berr_i = be; data_i = d;
        tick();
        sterm_i = 0; back_i = 0; inhibit_i = 0; berr_i = 0; data_i = '0;
        if (lat) begin
            m_line[m_ptr] = d;
            m_vld[m_ptr]  = 1'b1;
            m_ptr         = (m_ptr + 1) % 4;
        end
    endtask

    task automatic chk_line(input string req);
        chk(req, "vld", 64'(vld_o), 64'(m_vld));
        for (int k = 0; k < 4; k++) begin
            if (m_vld[k]) chk(req, "word", 64'(line_o[k*32 +: 32]), 64'(m_line[k]));
        end
    endtask

    task automatic t_reset();
        chk("R11", "as after reset", 64'(as_o), 0);
        chk("R11", "brq after reset", 64'(brq_o), 0);
        chk("R11", "vld after reset", 64'(vld_o), 0);
        chk("R11", "done after reset", 64'(done_o), 0);
        chk("R11", "status after reset", 64'(status_o), 0);
        chk("R10", "halt/grant after reset", 64'({halted_o, grant_o}), 0);
    endtask

    task automatic t_full_burst();
        open_acc(2, 1, 0, 0);
        chk("R3", "brq raised", 64'(brq_o), 1);
        chk("R4", "as ds", 64'({as_o, ds_o}), 64'b11);
        chk("R4", "addr", 64'(addr_o), 64'(BASE | 32'h8));
        put(1, 1, 0, 0, 32'hA0A0_0002, 1);
        chk_line("R5");
        chk("R3", "still bursting", 64'({as_o, brq_o}), 64'b11);
        put(0, 1, 0, 0, 32'hDEAD_BEEF, 0);
        chk_line("R5");
        put(1, 1, 0, 0, 32'hA0A0_0003, 1);
        chk("R4", "addr held", 64'(addr_o), 64'(BASE | 32'h8));
        put(1, 1, 0, 0, 32'hA0A0_0000, 1);
        chk("R6", "brq dropped after third", 64'(brq_o), 0);
        chk("R6", "as still high", 64'(as_o), 1);
        put(1, 0, 0, 0, 32'hA0A0_0001, 1);
        chk("R6", "done", 64'({done_o, as_o}), 64'b10);
        chk("R6", "status", 64'(status_o), 0);
        chk_line("R5");
        tick();
        chk("R11", "done pulse ends", 64'(done_o), 0);
        chk_line("R11");
    endtask

    task automatic t_blocked(input logic en, input logic frz, input logic rmw, input string req);
        open_acc(1, en, frz, rmw);
        chk(req, "brq low", 64'(brq_o), 0);
        put(0, 1, 0, 0, 32'h0, 0);
        chk(req, "brq low wait", 64'(brq_o), 0);
        put(1, 1, 0, 0, 32'hB1B1_0001, 1);
        chk(req, "single done", 64'({done_o, as_o, status_o}), 64'b1000);
        chk_line("R3");
    endtask

    task automatic t_no_ack();
        open_acc(3, 1, 0, 0);
        chk("R3", "brq", 64'(brq_o), 1);
        put(1, 0, 0, 0, 32'hC3C3_0003, 1);
        chk("R3", "single on no ack", 64'({done_o, as_o, status_o}), 64'b1000);
        chk_line("R3");
    endtask

    task automatic t_berr();
        open_acc(0, 1, 0, 0);
        put(1, 1, 0, 0, 32'hD0D0_0000, 1);
        put(0, 1, 0, 1, 32'hFFFF_FFFF, 0);
        chk("R7", "end on berr", 64'({done_o, as_o}), 64'b10);
        chk("R7", "status", 64'(status_o), 2);
        chk_line("R7");
    endtask

    task automatic t_inhibit();
        open_acc(1, 1, 0, 0);
        put(1, 1, 0, 0, 32'hE1E1_0001, 1);
        put(1, 1, 0, 0, 32'hE1E1_0002, 1);
        put(1, 1, 1, 0, 32'h5555_5555, 0);
        chk("R8", "end on inhibit", 64'({done_o, as_o}), 64'b10);
        chk("R8", "status", 64'(status_o), 1);
        chk_line("R8");
    endtask

    task automatic t_ackloss();
        open_acc(2, 1, 0, 0);
        put(1, 1, 0, 0, 32'hF2F2_0002, 1);
        put(1, 0, 0, 0, 32'hF2F2_0003, 1);
        chk("R9", "end on ack loss", 64'({done_o, as_o}), 64'b10);
        chk("R9", "status", 64'(status_o), 3);
        chk_line("R9");
    endtask

    task automatic t_halt();
        open_acc(0, 1, 0, 0);
        halt_i = 1'b1;
        put(1, 1, 0, 0, 32'h1111_0000, 1);
        put(1, 1, 0, 0, 32'h1111_0001, 1);
        chk("R10", "no halt mid burst", 64'(halted_o), 0);
        put(1, 1, 0, 0, 32'h1111_0002, 1);
        put(1, 1, 0, 0, 32'h1111_0003, 1);
        chk("R10", "halted at boundary", 64'({halted_o, grant_o}), 64'b10);
        chk_line("R5");
        addr_i = BASE; start_i = 1'b1;
        tick();
        start_i = 1'b0;
        chk("R10", "start ignored when halted", 64'(as_o), 0);
        chk("R11", "vld kept", 64'(vld_o), 64'hF);
        halt_i = 1'b0;
        tick();
        chk("R10", "halt released", 64'(halted_o), 0);
    endtask

    task automatic t_grant();
        open_acc(3, 1, 0, 0);
        busreq_i = 1'b1;
        put(1, 1, 0, 0, 32'h2222_0003, 1);
        chk("R10", "no grant mid burst", 64'(grant_o), 0);
        put(0, 0, 0, 1, 32'h0, 0);
        chk("R10", "grant at boundary", 64'(grant_o), 1);
        chk("R7", "status", 64'(status_o), 2);
        busreq_i = 1'b0;
        tick();
        chk("R10", "grant released", 64'(grant_o), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 0; start_i = 0; addr_i = '0; cache_en_i = 0; cache_frz_i = 0; rmw_i = 0;
        sterm_i = 0; back_i = 0; inhibit_i = 0; berr_i = 0; data_i = '0;
        halt_i = 0; busreq_i = 0;
        m_vld = '0; m_ptr = 0;
        for (int k = 0; k < 4; k++) m_line[k] = '0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_full_burst();
        t_blocked(1'b0, 1'b0, 1'b0, "R1");
        t_blocked(1'b1, 1'b1, 1'b0, "R1");
        t_blocked(1'b1, 1'b0, 1'b1, "R2");
        t_no_ack();
        t_berr();
        t_inhibit();
        t_ackloss();
        t_halt();
        t_grant();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule